// File: doc/BRIEF.md
# Multi-Bank Configurable GPIO Register Block

This block gives a host a byte-wide register window onto 48 general-purpose pins, grouped as six banks of eight. Each bank has one packed data byte. Each pin that is fitted in silicon has its own configuration byte. The configuration byte sets three things: whether the pin senses or drives, whether its logic level is inverted, and whether it drives actively in both directions or only pulls low.

The host uses a simple synchronous byte bus with an offset, a write strobe, a read strobe and 8-bit data. A write takes effect at the clock edge where it is strobed. A read returns its byte on the next cycle.

The configuration offsets are scattered and have gaps, and some bank positions have no pin behind them. The address decode therefore comes from a fixed map held in the package. Pad pin `b*8+p` is pin `p` of bank `b`.

Top module: `gpio_runtime_regs`

## Requirements
- R1: After reset, every fitted pin is an input whose configuration byte reads 0x01, every output latch is 0, and every `pad_oe` and `pad_out` bit is 0.
- R2: Bank data bytes sit at offsets 0x4B (bank 0) through 0x50 (bank 5). Per-pin configuration offsets, for pins 0..7 in order, are: bank 0 at 0x23-0x27 then 0x29-0x2B; bank 1 at 0x2C, 0x2D for pins 1-2 and 0x32 for pin 7; bank 2 at 0x33-0x37 for pins 0-4 and 0x39-0x3A for pins 6-7; bank 3 at 0x3B for pin 0, 0x3D for pin 2 and 0x6E, 0x6F, 0x72, 0x73 for pins 4-7; bank 4 at 0x3F-0x46; bank 5 at 0x47, 0x48, then 0x54-0x59.
- R3: In a configuration byte, bit 0 = 1 makes the pin an input (0 makes it an output), bit 1 = 1 inverts the pin level, and bit 7 = 1 selects open-drain drive. Reading the byte back returns those three bits, and bits 6..2 read as 0.
- R4: Bit n of a data-byte read is pin n of that bank. An input pin returns its `pad_in` level XOR its invert bit. An output pin returns its latch.
- R5: Bit n of a data-byte write loads the latch of pin n. A push-pull output drives `pad_out` = latch XOR invert with `pad_oe` = 1. An input pin never asserts `pad_oe`.
- R6: An open-drain output always has `pad_out` = 0. It asserts `pad_oe` only while latch XOR invert is 0.
- R7: Positions with no pin are bank 1 pins 0 and 3-6, bank 2 pin 5, and bank 3 pins 1 and 3. These positions read as 0 in their data byte, ignore data writes, and keep `pad_oe` and `pad_out` at 0.
- R8: An offset that is neither a data byte nor a configuration byte reads as 0x00, and a write to it changes no pin.
- R9: `rdata` takes the addressed byte on the cycle after `rd_en` is sampled high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| pad_in | input | 48 | Pad input levels |
| pad_out | output | 48 | Pad output values |
| pad_oe | output | 48 | Pad output enables |

## Verification
The first data pattern is an asymmetric input pattern on bank 0 (0xA5). It is read with and without an inverted pin, which shows the XOR is applied per pin rather than per bank. The bench then turns one pin of that bank into an output and reads the whole byte. This shows that the output pin returns its latch while its neighbours keep returning their pads. The same pin is then stepped through push-pull, inverted and open-drain settings with the latch at 1 and at 0, which separates the enable rule from the value rule. Finally, an all-ones pattern on the sparse bank, followed by writes to the configuration gaps and unmapped offsets, checks that absent positions stay silent.

// File: rtl/gpio_rt_pkg.sv
package gpio_rt_pkg;

    localparam int NUM_BANKS     = 6;
    localparam int PINS_PER_BANK = 8;
    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 8;
    localparam int NUM_PINS      = NUM_BANKS * PINS_PER_BANK;

    localparam logic [ADDR_W-1:0] DATA_BASE = 8'h4B;

    localparam int CFG_DIR_BIT = 0;
    localparam int CFG_INV_BIT = 1;
    localparam int CFG_OD_BIT  = 7;

    typedef struct packed {
        logic dir_in;
        logic inv;
        logic od;
        logic latch;
    } pin_state_t;

    // Configuration offset of one pin; 0 marks a position with no pin.
    function automatic logic [ADDR_W-1:0] cfg_offset(input int bank, input int pin);
        logic [ADDR_W-1:0] off;
        off = '0;
        case (bank)
            0: off = (pin < 5) ? ADDR_W'(8'h23 + pin) : ADDR_W'(8'h24 + pin);
            1: case (pin)
                   1: off = 8'h2C;
                   2: off = 8'h2D;
                   7: off = 8'h32;
                   default: off = '0;
               endcase
            2: off = (pin == 5) ? '0 : ADDR_W'(8'h33 + pin);
            3: case (pin)
                   0: off = 8'h3B;
                   2: off = 8'h3D;
                   4: off = 8'h6E;
                   5: off = 8'h6F;
                   6: off = 8'h72;
                   7: off = 8'h73;
                   default: off = '0;
               endcase
            4: off = ADDR_W'(8'h3F + pin);
            5: off = (pin < 2) ? ADDR_W'(8'h47 + pin) : ADDR_W'(8'h52 + pin);
            default: off = '0;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_rt_pkg::*;
#(
    parameter int BANK = 0,
    parameter int PIN  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              data_wr,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              rd_bit,
    output logic [DATA_W-1:0] cfg_rd
);

    localparam logic [ADDR_W-1:0] CFG_OFF = cfg_offset(BANK, PIN);
    localparam bit                PRESENT = (CFG_OFF != '0);

    generate
        if (PRESENT) begin : g_pin
            pin_state_t st_d, st_q;
            logic       cfg_hit;
            logic       drive;
            logic       unused_wbits;

            assign cfg_hit      = (addr == CFG_OFF);
            assign unused_wbits = ^wdata[6:2];

            always_comb begin
                st_d = st_q;
                if (wr_en && cfg_hit) begin
                    st_d.dir_in = wdata[CFG_DIR_BIT];
                    st_d.inv    = wdata[CFG_INV_BIT];
                    st_d.od     = wdata[CFG_OD_BIT];
                end
                if (data_wr) begin
                    st_d.latch = wdata[PIN];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '{dir_in: 1'b1, inv: 1'b0, od: 1'b0, latch: 1'b0};
                else        st_q <= st_d;
            end

            assign drive   = st_q.latch ^ st_q.inv;
            assign pad_out = st_q.od ? 1'b0 : (!st_q.dir_in && drive);
            assign pad_oe  = !st_q.dir_in && (!st_q.od || !drive);
            assign rd_bit  = st_q.dir_in ? (pad_in ^ st_q.inv) : st_q.latch;
            assign cfg_rd  = cfg_hit ? {st_q.od, 5'b0, st_q.inv, st_q.dir_in} : '0;

            // R5
            cfg_input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && cfg_hit && wdata[CFG_DIR_BIT]) |=> !pad_oe);

            // R5
            pp_latch_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (data_wr && !st_q.dir_in && !st_q.inv && !st_q.od)
                |=> (pad_oe && pad_out == $past(wdata[PIN])));

            // R6
            od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && cfg_hit && wdata[CFG_OD_BIT]) |=> !pad_out);
        end else begin : g_absent
            logic unused_in;
            assign unused_in = ^{clk, rst_n, addr, wr_en, wdata, data_wr, pad_in};
            assign pad_out   = 1'b0;
            assign pad_oe    = 1'b0;
            assign rd_bit    = 1'b0;
            assign cfg_rd    = '0;
        end
    endgenerate

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_rt_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [PINS_PER_BANK-1:0] pad_in,
    output logic [PINS_PER_BANK-1:0] pad_out,
    output logic [PINS_PER_BANK-1:0] pad_oe,
    output logic [DATA_W-1:0]        rd_byte
);

    localparam logic [ADDR_W-1:0] DATA_OFF = DATA_BASE + ADDR_W'(BANK);

    logic                     data_hit;
    logic                     data_wr;
    logic [PINS_PER_BANK-1:0] rd_bits;
    logic [DATA_W-1:0]        cfg_rd [PINS_PER_BANK];
    logic [DATA_W-1:0]        cfg_any;

    assign data_hit = (addr == DATA_OFF);
    assign data_wr  = wr_en && data_hit;

    for (genvar p = 0; p < PINS_PER_BANK; p++) begin : g_cell
        gpio_pin_cell #(.BANK(BANK), .PIN(p)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (addr),
            .wr_en   (wr_en),
            .wdata   (wdata),
            .data_wr (data_wr),
            .pad_in  (pad_in[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .rd_bit  (rd_bits[p]),
            .cfg_rd  (cfg_rd[p])
        );
    end

    always_comb begin
        cfg_any = '0;
        for (int p = 0; p < PINS_PER_BANK; p++) cfg_any |= cfg_rd[p];
    end

    assign rd_byte = data_hit ? DATA_W'(rd_bits) : cfg_any;

endmodule

// File: rtl/gpio_runtime_regs.sv
module gpio_runtime_regs
    import gpio_rt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] rd_mux;
    rd_state_t         rs_d, rs_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.BANK(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (addr),
            .wr_en   (wr_en),
            .wdata   (wdata),
            .pad_in  (pad_in [b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pad_out (pad_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pad_oe  (pad_oe [b*PINS_PER_BANK +: PINS_PER_BANK]),
            .rd_byte (bank_rd[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) rd_mux |= bank_rd[b];
        rs_d = rs_q;
        if (rd_en) rs_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rdata = rs_q.rdata;

    // R8
    low_gap_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < 8'h23) |=> (rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/gpio_runtime_regs_bench.sv
module gpio_runtime_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] pad_in = '0;
    logic [47:0] pad_out;
    logic [47:0] pad_oe;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_runtime_regs u_gpio_runtime_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected read byte into the scoreboard
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: a read sampled at a rising edge is compared at the following falling edge
    always @(posedge clk) rd_seen = rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            rd_seen = 1'b0;
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 64'(rdata), 64'hFFFF);
            end else begin
                check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check("watchdog", 64'd1, 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [47:0] oe_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe after reset", 64'(pad_oe), 64'h0);
        check("R1 pad_out after reset", 64'(pad_out), 64'h0);
        rd(8'h23, 8'h01, "R1 cfg bank0 pin0 reset");
        rd(8'h59, 8'h01, "R2 cfg bank5 pin7 offset");
        rd(8'h4B, 8'h00, "R1 data bank0 reset");

        // R4 input pattern with and without inversion
        pad_in[7:0] = 8'hA5;
        rd(8'h4B, 8'hA5, "R4 input levels bank0");
        wr(8'h24, 8'h03);
        rd(8'h24, 8'h03, "R3 cfg readback invert input");
        rd(8'h4B, 8'hA7, "R4 inverted input pin1");

        // R5 push-pull output
        wr(8'h23, 8'h00);
        wr(8'h4B, 8'h01);
        check("R5 pp oe bank0", 64'(pad_oe[7:0]), 64'h01);
        check("R5 pp out pin0", 64'(pad_out[0]), 64'h1);
        rd(8'h4B, 8'hA7, "R4 output pin reads latch");
        wr(8'h23, 8'h02);
        check("R5 inverted out pin0", 64'(pad_out[0]), 64'h0);
        check("R5 inverted oe pin0", 64'(pad_oe[0]), 64'h1);

        // R6 open drain
        wr(8'h23, 8'h80);
        check("R6 od released latch1", 64'(pad_oe[0]), 64'h0);
        check("R6 od out low", 64'(pad_out[0]), 64'h0);
        wr(8'h4B, 8'h00);
        check("R6 od pull latch0", 64'(pad_oe[0]), 64'h1);
        check("R6 od pull out", 64'(pad_out[0]), 64'h0);
        wr(8'h23, 8'h82);
        check("R6 od inverted released", 64'(pad_oe[0]), 64'h0);

        // R3 reserved bits, input never drives
        wr(8'h23, 8'hFF);
        rd(8'h23, 8'h83, "R3 reserved bits read zero");
        check("R5 input no oe", 64'(pad_oe[0]), 64'h0);

        // R7 absent pins on bank 1
        pad_in[15:8] = 8'hFF;
        rd(8'h4C, 8'h86, "R7 absent pins read zero");
        wr(8'h4C, 8'hFF);
        wr(8'h2C, 8'h00);
        wr(8'h2D, 8'h00);
        wr(8'h32, 8'h00);
        check("R7 absent no oe", 64'(pad_oe[15:8]), 64'h86);
        check("R7 absent no out", 64'(pad_out[15:8]), 64'h86);
        rd(8'h4C, 8'h86, "R7 bank1 readback");

        // R2 last bank mapping
        wr(8'h54, 8'h00);
        wr(8'h50, 8'h04);
        check("R2 bank5 pin2 oe", 64'(pad_oe[47:40]), 64'h04);
        check("R2 bank5 pin2 out", 64'(pad_out[47:40]), 64'h04);

        // R8 unmapped offsets
        rd(8'h00, 8'h00, "R8 offset 0x00");
        rd(8'hFF, 8'h00, "R8 offset 0xFF");
        rd(8'h28, 8'h00, "R8 gap 0x28");
        oe_before = pad_oe;
        wr(8'h28, 8'h00);
        wr(8'h38, 8'h00);
        check("R8 gap writes no effect", 64'(pad_oe), 64'(oe_before));

        // R9 hold
        rd(8'h23, 8'h83, "R9 read value");
        repeat (3) @(negedge clk);
        check("R9 rdata held", 64'(rdata), 64'h83);

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", 64'(exp_q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule